// File: doc/BRIEF.md
# Three-Channel Cross-Coupled Integral Bias Servo

This block closes a digital integral loop around the three phase biases of a nested interferometric modulator. Three demodulated error measurements come in, each with a strobe that marks a fresh sample. The block subtracts a programmable setpoint from each one. It then multiplies the resulting error vector by a programmable 3x3 gain matrix, so that the coupling between channels can be cancelled. Each row of the product feeds its own integrator. Each integrator carries 16 fractional bits below a 10-bit output code.

The integrator state is clamped to per-channel lower and upper code limits, which prevents windup. While feedback is disabled, the integrators track the manually set bias codes, so enabling feedback starts from the manual point without a jump. A hold, raised either by a software bit or by an external pin, freezes the bias codes. An option lets an active hold also switch off the high-speed output DAC. A separate kill pin switches that DAC off unconditionally. The three 10-bit codes drive PWM converters of roughly 1.6 mV per step.

Top module: `mzi_bias_servo`

## Requirements
- R1: While `rst_n` is low at a clock edge, all three bias codes become 0 and `dac_enable` becomes 0.
- R2: With `fb_enable` low and no hold, each bias code equals the matching `manual_vec` field one clock edge after that field is applied; the codes are not clamped in this mode.
- R3: When `fb_enable` rises with no strobe in flight, the bias codes keep their manual values until the first integrator update.
- R4: A `meas_valid` pulse sampled at edge e, with feedback enabled and no hold, updates each integrator after edge e+2. Channel i gains step_i = sum over j of G[i][j]*(meas_j - setpt_j), counted in units of 2^-16 code. The code is the integrator divided by 2^16, rounded toward minus infinity. Measurements, setpoints and gains are signed 16-bit values. Channel k sits at bits [16k+15:16k] of its vector. G[i][j] sits at bits [16(3i+j)+15:16(3i+j)] of `gain_vec`.
- R5: The off-diagonal gain terms G[i][j] with i != j move channel i in response to the error on channel j.
- R6: After each feedback update, the integrator state of channel i lies within [lo_i*2^16, hi_i*2^16], so its code lies within [lo_i, hi_i]. Here lo_i and hi_i are unsigned 10-bit fields at bits [10i+9:10i] of `lim_lo_vec` and `lim_hi_vec`.
- R7: Clamping applies to the integrator state itself. A step away from a limit therefore moves the code off that limit in the very next update, with no accumulated excess to unwind.
- R8: Hold is `sw_hold` OR `hold_pin`. While hold is active, the bias codes do not change, whether feedback is enabled or not.
- R9: One edge after hold is active with `dac_off_on_hold` high, `dac_enable` is 0. With that option low, or with no hold, `dac_enable` is 1, provided the kill pin is low.
- R10: `rf_kill_pin` high forces `dac_enable` to 0 one edge later, whatever the other controls are.
- R11: With feedback enabled, changes on the measurement inputs have no effect on the bias codes unless `meas_valid` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| meas_valid | input | 1 | Strobe marking a fresh measurement triple |
| meas_vec | input | 48 | Three signed 16-bit demodulated measurements |
| setpt_vec | input | 48 | Three signed 16-bit setpoints |
| gain_vec | input | 144 | 3x3 signed 16-bit gain matrix, row-major |
| lim_lo_vec | input | 30 | Three 10-bit lower code limits |
| lim_hi_vec | input | 30 | Three 10-bit upper code limits |
| manual_vec | input | 30 | Three 10-bit manual bias codes |
| fb_enable | input | 1 | Feedback on |
| sw_hold | input | 1 | Software hold |
| hold_pin | input | 1 | External hold input |
| dac_off_on_hold | input | 1 | An active hold also switches the high-speed DAC off |
| rf_kill_pin | input | 1 | External input that switches the high-speed DAC off |
| bias_code_vec | output | 30 | Three 10-bit bias codes for the PWM converters |
| dac_enable | output | 1 | High-speed output DAC enable |

## Verification
A measurement strobe passes through three registers: the setpoint subtraction, the matrix product and the integrator. Its effect on the codes is therefore due after the second edge following the edge that samples the strobe. The bench drops the strobe at the next falling edge and reads the codes two falling edges later, before any further stimulus. Manual tracking and the DAC enable both come from a single register. Those results are read at the first falling edge after the edge that captures the change. The expected codes come from a wide integer model of each integrator held in the bench.

// File: rtl/bias_servo_pkg.sv
// Shared types for the bias servo.
// Assumes nothing beyond IEEE 1800-2017 packages.
package bias_servo_pkg;

    // What an integrator does at the next clock edge.
    typedef enum logic [1:0] {
        UPD_TRACK  = 2'd0,  // follow the manual code
        UPD_FREEZE = 2'd1,  // hold the present state
        UPD_STEP   = 2'd2,  // add the matrix step, then clamp
        UPD_IDLE   = 2'd3   // enabled, no new sample
    } upd_mode_t;

endpackage

// File: rtl/bias_err_stage.sv
// Setpoint subtraction stage.
// Registers meas - setpt for every channel on each strobe, one extra bit wide
// so that the difference cannot overflow. It forwards the strobe one cycle later.
// Assumes signed two's-complement inputs packed channel 0 in the low bits.
module bias_err_stage #(
    parameter int NCH  = 3,
    parameter int IN_W = 16,
    localparam int EW  = IN_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_in,
    input  logic [NCH*IN_W-1:0] meas_vec,
    input  logic [NCH*IN_W-1:0] setpt_vec,
    output logic [NCH*EW-1:0]   err_vec,
    output logic                valid_out
);

    // Strobe delay matching the error register.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_out <= 1'b0;
        else        valid_out <= valid_in;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic signed [EW-1:0] m_ext;
        logic signed [EW-1:0] s_ext;
        assign m_ext = EW'(signed'(meas_vec[c*IN_W +: IN_W]));
        assign s_ext = EW'(signed'(setpt_vec[c*IN_W +: IN_W]));

        // Capture the error of this channel on a strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)        err_vec[c*EW +: EW] <= '0;
            else if (valid_in) err_vec[c*EW +: EW] <= m_ext - s_ext;
        end
    end

endmodule

// File: rtl/bias_gain_matrix.sv
// Cross-coupling gain matrix.
// Computes step_i = sum_j G[i][j] * err_j for every output row and registers
// the result together with a delayed strobe. G is packed row-major.
// Assumes signed errors and gains; the sum width covers NCH full-scale products.
module bias_gain_matrix #(
    parameter int NCH    = 3,
    parameter int EW     = 17,
    parameter int GAIN_W = 16,
    localparam int DW    = EW + GAIN_W + $clog2(NCH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      valid_in,
    input  logic [NCH*EW-1:0]         err_vec,
    input  logic [NCH*NCH*GAIN_W-1:0] gain_vec,
    output logic [NCH*DW-1:0]         step_vec,
    output logic                      valid_out
);

    // Strobe delay matching the product register.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_out <= 1'b0;
        else        valid_out <= valid_in;
    end

    for (genvar r = 0; r < NCH; r++) begin : g_row
        logic signed [DW-1:0] row_sum;

        // Multiply-accumulate across one row of the matrix.
        always_comb begin
            row_sum = '0;
            for (int k = 0; k < NCH; k++) begin
                row_sum = row_sum
                    + DW'(signed'(err_vec[k*EW +: EW]))
                    * DW'(signed'(gain_vec[(r*NCH+k)*GAIN_W +: GAIN_W]));
            end
        end

        // Register the row result on a strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)        step_vec[r*DW +: DW] <= '0;
            else if (valid_in) step_vec[r*DW +: DW] <= row_sum;
        end
    end

endmodule

// File: rtl/bias_integrator.sv
// One clamped integrator channel.
// Holds an OUT_W.FRAC fixed-point state. While disabled it tracks the manual
// code, which makes enabling bumpless. While enabled it adds the step on each
// strobe and clamps the state itself to [lo, hi] codes. Hold freezes it.
// Assumes lo <= hi. The code is the integer part of the state.
module bias_integrator
    import bias_servo_pkg::*;
#(
    parameter int DW    = 35,
    parameter int OUT_W = 10,
    parameter int FRAC  = 16,
    localparam int ACC_W = OUT_W + FRAC + 1,
    localparam int SUM_W = ((DW > ACC_W) ? DW : ACC_W) + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                hold,
    input  logic                step_valid,
    input  logic signed [DW-1:0] step,
    input  logic [OUT_W-1:0]    manual,
    input  logic [OUT_W-1:0]    lim_lo,
    input  logic [OUT_W-1:0]    lim_hi,
    output logic [OUT_W-1:0]    code
);

    logic signed [ACC_W-1:0] acc_q;
    logic signed [SUM_W-1:0] sum_w;
    logic signed [SUM_W-1:0] lo_w;
    logic signed [SUM_W-1:0] hi_w;
    logic signed [SUM_W-1:0] clamped_w;
    upd_mode_t               mode;

    // Pick the action for this cycle; hold outranks everything.
    always_comb begin
        if (hold)            mode = UPD_FREEZE;
        else if (!enable)    mode = UPD_TRACK;
        else if (step_valid) mode = UPD_STEP;
        else                 mode = UPD_IDLE;
    end

    // Candidate sum and limits in a width that cannot overflow.
    always_comb begin
        sum_w = SUM_W'(acc_q) + SUM_W'(step);
        lo_w  = signed'(SUM_W'({lim_lo, {FRAC{1'b0}}}));
        hi_w  = signed'(SUM_W'({lim_hi, {FRAC{1'b0}}}));
        if (sum_w < lo_w)      clamped_w = lo_w;
        else if (sum_w > hi_w) clamped_w = hi_w;
        else                   clamped_w = sum_w;
    end

    // Integrator state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            case (mode)
                UPD_TRACK: acc_q <= signed'(ACC_W'({manual, {FRAC{1'b0}}}));
                UPD_STEP:  acc_q <= ACC_W'(clamped_w);
                default:   acc_q <= acc_q;
            endcase
        end
    end

    assign code = acc_q[FRAC +: OUT_W];

    // R2
    manual_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !enable && !hold) |=> (code == $past(manual)));

    // R6
    clamp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && mode == UPD_STEP) |=> (code >= $past(lim_lo) && code <= $past(lim_hi)));

    // R8
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && hold) |=> $stable(code));

    // R11
    no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && enable && !hold && !step_valid) |=> $stable(code));

endmodule

// File: rtl/mzi_bias_servo.sv
// Three-channel cross-coupled integral bias servo, top level.
// Pipeline: setpoint subtraction -> gain matrix -> clamped integrators, so
// a strobe sampled at edge e reaches the codes after edge e+2. The hold is the
// OR of the software bit and the pin. The DAC enable is registered.
// Assumes the limit pairs satisfy lo <= hi.
module mzi_bias_servo #(
    parameter int NCH    = 3,
    parameter int IN_W   = 16,
    parameter int GAIN_W = 16,
    parameter int OUT_W  = 10,
    parameter int FRAC   = 16,
    localparam int EW    = IN_W + 1,
    localparam int DW    = EW + GAIN_W + $clog2(NCH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      meas_valid,
    input  logic [NCH*IN_W-1:0]       meas_vec,
    input  logic [NCH*IN_W-1:0]       setpt_vec,
    input  logic [NCH*NCH*GAIN_W-1:0] gain_vec,
    input  logic [NCH*OUT_W-1:0]      lim_lo_vec,
    input  logic [NCH*OUT_W-1:0]      lim_hi_vec,
    input  logic [NCH*OUT_W-1:0]      manual_vec,
    input  logic                      fb_enable,
    input  logic                      sw_hold,
    input  logic                      hold_pin,
    input  logic                      dac_off_on_hold,
    input  logic                      rf_kill_pin,
    output logic [NCH*OUT_W-1:0]      bias_code_vec,
    output logic                      dac_enable
);

    logic                 hold_any;
    logic [NCH*EW-1:0]    err_vec;
    logic                 err_valid;
    logic [NCH*DW-1:0]    step_vec;
    logic                 step_valid;

    assign hold_any = sw_hold | hold_pin;

    // Register the high-speed DAC enable from kill pin and hold gating.
    always_ff @(posedge clk) begin
        if (!rst_n) dac_enable <= 1'b0;
        else        dac_enable <= !rf_kill_pin && !(hold_any && dac_off_on_hold);
    end

    bias_err_stage #(.NCH(NCH), .IN_W(IN_W)) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (meas_valid),
        .meas_vec  (meas_vec),
        .setpt_vec (setpt_vec),
        .err_vec   (err_vec),
        .valid_out (err_valid)
    );

    bias_gain_matrix #(.NCH(NCH), .EW(EW), .GAIN_W(GAIN_W)) u_mat (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (err_valid),
        .err_vec   (err_vec),
        .gain_vec  (gain_vec),
        .step_vec  (step_vec),
        .valid_out (step_valid)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_int
        bias_integrator #(.DW(DW), .OUT_W(OUT_W), .FRAC(FRAC)) u_int (
            .clk        (clk),
            .rst_n      (rst_n),
            .enable     (fb_enable),
            .hold       (hold_any),
            .step_valid (step_valid),
            .step       (signed'(step_vec[c*DW +: DW])),
            .manual     (manual_vec[c*OUT_W +: OUT_W]),
            .lim_lo     (lim_lo_vec[c*OUT_W +: OUT_W]),
            .lim_hi     (lim_hi_vec[c*OUT_W +: OUT_W]),
            .code       (bias_code_vec[c*OUT_W +: OUT_W])
        );
    end

    // R10
    rf_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && rf_kill_pin) |=> !dac_enable);

    // R9
    hold_dac_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && hold_any && dac_off_on_hold) |=> !dac_enable);

    // R9
    dac_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !rf_kill_pin && !(hold_any && dac_off_on_hold)) |=> dac_enable);

endmodule

// File: tb/mzi_bias_servo_test.sv
module mzi_bias_servo_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic meas_valid = 1'b0;
    logic [47:0]  meas_vec, setpt_vec;
    logic [143:0] gain_vec;
    logic [29:0]  lim_lo_vec, lim_hi_vec, manual_vec;
    logic fb_enable = 1'b0, sw_hold = 1'b0, hold_pin = 1'b0;
    logic dac_off_on_hold = 1'b0, rf_kill_pin = 1'b0;
    logic [29:0] bias_code_vec;
    logic dac_enable;

    int meas[3], sp[3], g[3][3], lo[3], hi[3], man[3];
    longint acc_m[3];
    int n_checks = 0, n_errors = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 3; i++) begin
            meas_vec[i*16 +: 16]   = 16'(meas[i]);
            setpt_vec[i*16 +: 16]  = 16'(sp[i]);
            lim_lo_vec[i*10 +: 10] = 10'(lo[i]);
            lim_hi_vec[i*10 +: 10] = 10'(hi[i]);
            manual_vec[i*10 +: 10] = 10'(man[i]);
            for (int j = 0; j < 3; j++) gain_vec[(i*3+j)*16 +: 16] = 16'(g[i][j]);
        end
    end

    mzi_bias_servo uut (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .meas_vec(meas_vec),
        .setpt_vec(setpt_vec), .gain_vec(gain_vec), .lim_lo_vec(lim_lo_vec),
        .lim_hi_vec(lim_hi_vec), .manual_vec(manual_vec), .fb_enable(fb_enable),
        .sw_hold(sw_hold), .hold_pin(hold_pin), .dac_off_on_hold(dac_off_on_hold),
        .rf_kill_pin(rf_kill_pin), .bias_code_vec(bias_code_vec), .dac_enable(dac_enable)
    );

    task automatic check_val(string tag, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic check_codes(string tag);
        for (int i = 0; i < 3; i++)
            check_val($sformatf("%s ch%0d", tag, i),
                      longint'(bias_code_vec[i*10 +: 10]), acc_m[i] >>> 16);
    endtask

    // Model of one feedback update (R4, R5, R6, R7).
    task automatic model_step();
        for (int i = 0; i < 3; i++) begin
            longint s = acc_m[i];
            for (int j = 0; j < 3; j++)
                s += longint'(g[i][j]) * longint'(meas[j] - sp[j]);
            if (s < (longint'(lo[i]) <<< 16)) s = longint'(lo[i]) <<< 16;
            if (s > (longint'(hi[i]) <<< 16)) s = longint'(hi[i]) <<< 16;
            acc_m[i] = s;
        end
    endtask

    // One strobe; codes are read two falling edges after the strobe drops.
    task automatic pulse(bit updates);
        @(negedge clk) meas_valid = 1'b1;
        @(negedge clk) meas_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        if (updates) model_step();
    endtask

    task automatic track_manual();
        for (int i = 0; i < 3; i++) acc_m[i] = longint'(man[i]) <<< 16;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        for (int i = 0; i < 3; i++) acc_m[i] = 0;
        check_codes("R1 reset codes");
        check_val("R1 reset dac_enable", longint'(dac_enable), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_manual();
        man = '{100, 512, 1023};
        @(negedge clk); @(negedge clk);
        track_manual();
        check_codes("R2 manual pass");
        man = '{7, 300, 64};
        @(negedge clk);
        track_manual();
        check_codes("R2 manual change");
        man = '{100, 512, 1000};
        @(negedge clk);
        track_manual();
    endtask

    task automatic t_bumpless();
        fb_enable = 1'b1;
        repeat (3) @(negedge clk);
        check_codes("R3 bumpless enable");
    endtask

    task automatic t_diag();
        g = '{'{16384, 0, 0}, '{0, 16384, 0}, '{0, 0, 16384}};
        sp = '{0, 100, -50};
        meas = '{400, 60, -50};
        pulse(1);
        check_codes("R4 diagonal step");
    endtask

    task automatic t_cross();
        g = '{'{0, 8192, 0}, '{0, 0, -4096}, '{2048, 0, 0}};
        sp = '{0, 0, 0};
        meas = '{-800, 1000, 600};
        pulse(1);
        check_codes("R5 cross coupling");
    endtask

    task automatic t_clamp();
        g = '{'{32767, 0, 0}, '{0, 32767, 0}, '{0, 0, 32767}};
        lo = '{0, 50, 0};
        hi = '{900, 1023, 1023};
        meas = '{30000, -30000, 0};
        pulse(1);
        check_codes("R6 clamp limits");
        check_val("R6 upper limit", longint'(bias_code_vec[9:0]), 900);
        check_val("R6 lower limit", longint'(bias_code_vec[19:10]), 50);
        pulse(1);
        check_codes("R6 clamp repeat");
        meas = '{-500, 500, 0};
        pulse(1);
        check_codes("R7 leave limit");
        check_val("R7 lower unwound", longint'(bias_code_vec[19:10]), 50 + ((500*32767) >> 16));
    endtask

    task automatic t_novalid();
        meas = '{20000, 20000, -20000};
        repeat (5) @(negedge clk);
        check_codes("R11 no strobe");
    endtask

    task automatic t_hold();
        sw_hold = 1'b1;
        pulse(0);
        check_codes("R8 software hold");
        sw_hold = 1'b0;
        hold_pin = 1'b1;
        pulse(0);
        check_codes("R8 pin hold");
        fb_enable = 1'b0;
        man = '{10, 20, 30};
        repeat (3) @(negedge clk);
        check_codes("R8 hold while disabled");
        hold_pin = 1'b0;
        @(negedge clk);
        track_manual();
        check_codes("R2 resume tracking");
    endtask

    task automatic t_dac();
        check_val("R9 dac on idle", longint'(dac_enable), 1);
        sw_hold = 1'b1;
        @(negedge clk);
        check_val("R9 hold option off", longint'(dac_enable), 1);
        dac_off_on_hold = 1'b1;
        @(negedge clk);
        check_val("R9 hold gates dac", longint'(dac_enable), 0);
        sw_hold = 1'b0;
        hold_pin = 1'b1;
        @(negedge clk);
        check_val("R9 pin hold gates dac", longint'(dac_enable), 0);
        hold_pin = 1'b0;
        @(negedge clk);
        check_val("R9 release", longint'(dac_enable), 1);
        rf_kill_pin = 1'b1;
        @(negedge clk);
        check_val("R10 kill pin", longint'(dac_enable), 0);
        dac_off_on_hold = 1'b0;
        fb_enable = 1'b1;
        @(negedge clk);
        check_val("R10 kill overrides", longint'(dac_enable), 0);
        rf_kill_pin = 1'b0;
        @(negedge clk);
        check_val("R10 kill released", longint'(dac_enable), 1);
    endtask

    initial begin
        meas = '{0, 0, 0};
        sp = '{0, 0, 0};
        g = '{'{0, 0, 0}, '{0, 0, 0}, '{0, 0, 0}};
        lo = '{0, 0, 0};
        hi = '{1023, 1023, 1023};
        man = '{0, 0, 0};
        t_reset();
        t_manual();
        t_bumpless();
        t_diag();
        t_cross();
        t_clamp();
        t_novalid();
        t_hold();
        t_dac();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule